// File: doc/BRIEF.md
# Channel-Programmable Feedback Divider

This block divides an input clock by a channel-selected integer and sends one pulse per division period to a phase detector. The ratio is three decimal digits. A range select picks 2 or 3 for the hundreds digit. Two BCD select inputs give the tens digit and the units digit. Internally the units and tens positions are decade down counters, and the hundreds position is a small up counter that starts from a state set by the range select.

An end-of-count decode looks for the hundreds stage at its final state, the units digit at 2 and a tens condition. One register stage then produces the output pulse, and that pulse also reloads every stage. A transmit/receive key input moves the tens condition from the tens borrow (digit at 0) to the tens digit reading 3. This makes every period 30 clocks shorter in receive mode, which gives a fixed offset in the synthesized frequency.

The inputs are sampled only when the counters reload, so a change in the middle of a period never cuts that period short. A debug output shows the live counter state.

Top module: `chan_fb_divider`

## Requirements
- R1: With key low (transmit), consecutive output pulses are exactly L clocks apart, where L = 100*H + 10*T + U. H is 3 when range select is high and 2 when it is low. T and U are the tens and units selects.
- R2: With key high (receive), consecutive output pulses are exactly L-30 clocks apart.
- R3: The hundreds stage loads start state 0 when range select is high and start state 1 when range select is low. It counts up to its final state 3.
- R4: The output pulse is high for exactly one clock cycle per period.
- R5: Key, range and digit selects are sampled only on the rising edge that follows a pulse cycle, or while reset is high. A change during a period leaves that period's length unchanged.
- R6: The debug count is packed as hundreds state in bits 9:8, tens digit in bits 7:4 and units digit in bits 3:0. After a reload it equals the loaded values. It then counts down by one per clock with decimal borrow, and each tens borrow advances the hundreds state. The digits never leave 0..9 and the hundreds state never wraps past 3.
- R7: A units or tens select above 9 is loaded as 9.
- R8: While reset is high the pulse is low and the counters hold the loaded inputs. After reset is released, the first pulse is high in the cycle after the (P-1)th rising edge, where P is the period from R1 or R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock being divided |
| rst | input | 1 | Synchronous active-high reset; loads the counters from the inputs |
| units_sel | input | 4 | Units digit of the ratio (BCD) |
| tens_sel | input | 4 | Tens digit of the ratio (BCD) |
| range_hi | input | 1 | 1 selects the 300 range, 0 the 200 range |
| rx_key | input | 1 | 1 selects receive mode (ratio minus 30) |
| div_pulse | output | 1 | One-clock pulse per division period |
| dbg_count | output | 10 | Live counter state {hundreds, tens, units} |

## Verification
The output pulse is due P-1 rising edges after a reload, and the next reload happens on the edge right after the pulse cycle. The debug count changes on each rising edge, and its new value reflects inputs sampled at that same edge. The bench's behavioural model advances on the same rising edge as the design and is compared at the following falling edge, so each result is checked in the exact cycle it is due. Pulse spacing is measured in falling-edge counts between observed pulses and compared with the period fixed at that period's reload. The time from reset release to the first pulse is counted separately.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;

    localparam int DIGIT_W     = 4;
    localparam int HUND_W      = 2;
    localparam int NDIG        = 2;
    localparam int DIGIT_MAX   = 9;
    localparam int UNITS_TAP   = 2;
    localparam int RX_TENS_TAP = 3;
    localparam int HUND_HI_ST  = 0;
    localparam int HUND_LO_ST  = 1;
    localparam int DBG_W       = HUND_W + NDIG * DIGIT_W;

    typedef enum logic {
        KEY_TX = 1'b0,
        KEY_RX = 1'b1
    } key_mode_e;

    typedef struct packed {
        logic [HUND_W-1:0]  hund;
        logic [DIGIT_W-1:0] tens;
        logic [DIGIT_W-1:0] units;
    } chan_state_t;

    function automatic logic [DIGIT_W-1:0] clamp_digit(input logic [DIGIT_W-1:0] d);
        return (d > DIGIT_W'(DIGIT_MAX)) ? DIGIT_W'(DIGIT_MAX) : d;
    endfunction

    function automatic logic [HUND_W-1:0] hund_start(input logic hi);
        return hi ? HUND_W'(HUND_HI_ST) : HUND_W'(HUND_LO_ST);
    endfunction

endpackage

// File: rtl/fbdiv_decade.sv
module fbdiv_decade #(
    parameter int W   = 4,
    parameter int MAX = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec_en,
    output logic [W-1:0] q,
    output logic         at_zero
);
    assign at_zero = (q == '0);

    always_ff @(posedge clk) begin
        if (load)
            q <= load_val;
        else if (dec_en)
            q <= at_zero ? W'(MAX) : q - 1'b1;
    end

    // R6: digit stays a decimal digit
    assert_digit_bcd_R6: assert property (@(posedge clk) disable iff (rst)
        q <= W'(MAX));
endmodule

// File: rtl/fbdiv_hund.sv
module fbdiv_hund #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] start,
    input  logic         inc,
    output logic [W-1:0] q,
    output logic         full
);
    assign full = &q;

    always_ff @(posedge clk) begin
        if (load)
            q <= start;
        else if (inc)
            q <= q + 1'b1;
    end

    // R6: hundreds stage is reloaded before it could wrap
    assert_hund_no_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        full |-> !(inc && !load));
endmodule

// File: rtl/fbdiv_eoc.sv
module fbdiv_eoc (
    input  logic clk,
    input  logic rst,
    input  logic hund_full,
    input  logic tens_hit,
    input  logic units_hit,
    output logic pulse
);
    logic j_cond;
    assign j_cond = hund_full & tens_hit & units_hit;

    always_ff @(posedge clk) begin
        if (rst)
            pulse <= 1'b0;
        else
            pulse <= j_cond;
    end

    // R4: pulse lasts one cycle
    assert_pulse_single_R4: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);
endmodule

// File: rtl/chan_fb_divider.sv
module chan_fb_divider
    import fbdiv_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [DIGIT_W-1:0] units_sel,
    input  logic [DIGIT_W-1:0] tens_sel,
    input  logic               range_hi,
    input  logic               rx_key,
    output logic               div_pulse,
    output logic [DBG_W-1:0]   dbg_count
);
    logic                load;
    logic [DIGIT_W-1:0]  dig_q    [NDIG];
    logic [DIGIT_W-1:0]  dig_init [NDIG];
    logic [NDIG-1:0]     dig_zero;
    logic [NDIG-1:0]     dig_en;
    logic [HUND_W-1:0]   hund_q;
    logic                hund_full;
    logic                hund_inc;
    key_mode_e           mode_q;
    logic                tens_hit;
    logic                units_hit;
    chan_state_t         cur;

    assign load        = rst | div_pulse;
    assign dig_init[0] = clamp_digit(units_sel);
    assign dig_init[1] = clamp_digit(tens_sel);

    for (genvar g = 0; g < NDIG; g++) begin : g_dig
        if (g == 0) begin : g_first
            assign dig_en[g] = 1'b1;
        end else begin : g_rest
            assign dig_en[g] = &dig_zero[g-1:0];
        end
        fbdiv_decade #(.W(DIGIT_W), .MAX(DIGIT_MAX)) u_dig (
            .clk     (clk),
            .rst     (rst),
            .load    (load),
            .load_val(dig_init[g]),
            .dec_en  (dig_en[g]),
            .q       (dig_q[g]),
            .at_zero (dig_zero[g])
        );
    end

    assign hund_inc = &dig_zero;

    fbdiv_hund #(.W(HUND_W)) u_hund (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .start(hund_start(range_hi)),
        .inc  (hund_inc),
        .q    (hund_q),
        .full (hund_full)
    );

    always_ff @(posedge clk) begin
        if (load)
            mode_q <= rx_key ? KEY_RX : KEY_TX;
    end

    assign tens_hit  = (mode_q == KEY_RX) ? (dig_q[1] == DIGIT_W'(RX_TENS_TAP))
                                          : dig_zero[1];
    assign units_hit = (dig_q[0] == DIGIT_W'(UNITS_TAP));

    fbdiv_eoc u_eoc (
        .clk      (clk),
        .rst      (rst),
        .hund_full(hund_full),
        .tens_hit (tens_hit),
        .units_hit(units_hit),
        .pulse    (div_pulse)
    );

    assign cur.hund  = hund_q;
    assign cur.tens  = dig_q[1];
    assign cur.units = dig_q[0];
    assign dbg_count = cur;

    // R6 and R5: after a pulse the counters hold the inputs seen at the reload edge
    assert_reload_value_R6: assert property (@(posedge clk) disable iff (rst)
        div_pulse |=> dbg_count == {$past(hund_start(range_hi)),
                                    $past(clamp_digit(tens_sel)),
                                    $past(clamp_digit(units_sel))});

    // R5: mode is held between reloads
    assert_mode_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(div_pulse) && !$past(rst)) |-> $stable(mode_q));
endmodule

// File: tb/sim_chan_fb_divider.sv
`timescale 1ns/1ps
module sim_chan_fb_divider;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] units_sel = 4'd4;
    logic [3:0] tens_sel  = 4'd3;
    logic       range_hi  = 1'b1;
    logic       rx_key    = 1'b0;
    logic       div_pulse;
    logic [9:0] dbg_count;

    chan_fb_divider u0 (
        .clk(clk), .rst(rst), .units_sel(units_sel), .tens_sel(tens_sel),
        .range_hi(range_hi), .rx_key(rx_key),
        .div_pulse(div_pulse), .dbg_count(dbg_count)
    );

    always #2.5 clk = ~clk;

    int total = 0, bad = 0;
    int m_cnt = 0, m_L = 0, m_P = 0;
    bit m_pulse = 0, m_rx = 0, m_lo = 0, m_sat = 0;
    bit mon_on = 0, have_prev = 0, r5_watch = 0;
    int cyc = 0, prev = 0, pulses = 0, wd = 0;

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int sat(int d);
        return (d > 9) ? 9 : d;
    endfunction

    // behavioural reference model
    always @(posedge clk) begin
        if (rst || m_pulse) begin
            m_cnt   = 0;
            m_L     = (range_hi ? 300 : 200) + sat(tens_sel) * 10 + sat(units_sel);
            m_rx    = rx_key;
            m_P     = m_L - (m_rx ? 30 : 0);
            m_lo    = !range_hi;
            m_sat   = (tens_sel > 9) || (units_sel > 9);
            m_pulse = 0;
        end else begin
            m_cnt++;
            m_pulse = (m_cnt == m_P - 1);
        end
    end

    always @(negedge clk) begin
        if (mon_on) begin
            int rem, expd;
            string tag;
            cyc++;
            rem  = m_L - m_cnt;
            expd = ((3 - rem / 100) << 8) | (((rem / 10) % 10) << 4) | (rem % 10);
            check("R6 debug count", int'(dbg_count), expd);
            check("R4 pulse level", int'(div_pulse), int'(m_pulse));
            if (rst) have_prev = 0;
            if (div_pulse) begin
                if (have_prev) begin
                    if (r5_watch)   begin tag = "R5 spacing after mid-period change"; r5_watch = 0; end
                    else if (m_sat) tag = "R7 spacing with clamped digits";
                    else if (m_lo)  tag = "R3 spacing in 200 range";
                    else if (m_rx)  tag = "R2 spacing in receive";
                    else            tag = "R1 spacing in transmit";
                    check(tag, cyc - prev, m_P);
                end
                have_prev = 1;
                prev = cyc;
                pulses++;
            end
        end
    end

    always @(posedge clk) begin
        wd++;
        if (wd == 150000) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog actual=%0d expected=%0d", wd, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wait_pulses(int n);
        int target = pulses + n;
        while (pulses < target) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        mon_on = 1;
        @(negedge clk);
        check("R8 pulse low in reset", int'(div_pulse), 0);
        check("R8 count loaded in reset", int'(dbg_count), (0 << 8) | (3 << 4) | 4);
        rst = 1'b0;
        begin
            int k = 0;
            for (int i = 0; i < 1000; i++) begin
                @(negedge clk);
                k++;
                if (div_pulse) break;
            end
            check("R8 first pulse delay", k, 333);
        end
        wait_pulses(2);
        repeat (100) @(negedge clk);
        rx_key = 1'b1;
        r5_watch = 1;
        wait_pulses(3);
        range_hi = 1'b0; tens_sel = 4'd9; units_sel = 4'd9;
        wait_pulses(3);
        rx_key = 1'b0;
        wait_pulses(3);
        tens_sel = 4'd0; units_sel = 4'd0;
        wait_pulses(3);
        rx_key = 1'b1;
        wait_pulses(3);
        range_hi = 1'b1; tens_sel = 4'd12; units_sel = 4'd15; rx_key = 1'b0;
        wait_pulses(3);
        rx_key = 1'b1;
        wait_pulses(3);
        tens_sel = 4'd0; units_sel = 4'd0;
        wait_pulses(3);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule